// File: doc/BRIEF.md
# Overlapped Register-Move Sequencer

This block carries out one move instruction whose destination is always a register and whose source is a register or a memory word. It is a multi-cycle control unit with a small datapath. It reads through a synchronous memory port, which accepts at most one request per cycle and returns data one cycle later. It holds eight 32-bit registers.

The cycle count is kept low by overlapping micro-steps that share no unit and do not depend on each other:

- The instruction pointer advances past the opcode in the same cycle the opcode is decoded.
- The pointer advances past a displacement either in the cycle that forms the effective address or in the cycle that issues the operand read.

A caller loads the registers while the block is idle, presents a start address and pulses `start`. It then waits for `done`. A cycle counter reports how long the instruction took, which makes the saving for each addressing mode visible at the ports.

Top module: `mov_seq`

## Requirements
- R1: After reset, `busy`, `done`, `mem_re`, `ip` and `cycles` are all zero.
- R2: Sampling `start` while idle loads the pointer from `start_ip`. The next cycle issues a memory read at that address, and this is the opcode read.
- R3: The opcode byte is the low byte of the returned word. Bits [7:6] select the mode: 00 register, 01 register-indirect, 10 direct displacement, 11 base plus displacement. Bits [5:3] name the source or base register, and bits [2:0] name the destination register.
- R4: Register mode copies the source register into the destination and completes in 3 cycles.
- R5: Register-indirect mode loads the 32-bit little-endian word at the low address bits of the base register and completes in 5 cycles.
- R6: Direct mode reads a 16-bit little-endian displacement from the low half of the word at the byte after the opcode. It loads the word at that displacement and completes in 5 cycles.
- R7: Base-plus-displacement mode loads the word at the base register's low address bits plus the displacement, modulo 2^AW. It completes in 6 cycles.
- R8: On completion the pointer equals the opcode address plus 1. Modes 10 and 11 add a further 2.
- R9: `done` is high for exactly one cycle, the cycle in which the destination register is written. `cycles` then equals the count of busy cycles, and it holds that value until the next start.
- R10: A `start` that arrives while busy is ignored. The instruction's result and final pointer do not change.
- R11: The external register write port takes effect only while idle. A write attempted while busy leaves the register unchanged.
- R12: No memory read is issued in the register-write cycle. In every memory mode, the write cycle directly follows the operand read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin one instruction (idle only) |
| start_ip | input | AW | Address of the opcode byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle pulse at register write |
| cycles | output | CW | Busy cycles of the last instruction |
| ip | output | AW | Instruction pointer |
| mem_re | output | 1 | Memory read request |
| mem_addr | output | AW | Byte address of the read |
| mem_rdata | input | DW | Read data, one cycle after request |
| ext_we | input | 1 | External register write enable |
| ext_idx | input | 3 | External write register index |
| ext_wdata | input | DW | External write data |
| rd_idx | input | 3 | Register read-back index |
| rd_data | output | DW | Register read-back data |

## Verification
The situation hardest to reach from the ports is an overlapped cycle that coincides with traffic the block must refuse. An example is a second `start` or an external register write arriving in the opcode-read cycle of a base-plus-displacement move. A wrong merge or a leaky guard there would shift the pointer or corrupt a register without changing the cycle count.

The bench sweeps all 256 opcodes, each with fresh register contents and a fresh start address, and computes the expected data, pointer and cycle count arithmetically. It then replays a base-plus-displacement move while driving a new `start` and a write to an unrelated register during its opcode-read cycle.

// File: rtl/mov_seq_pkg.sv
package mov_seq_pkg;

    localparam int OPC_W     = 8;
    localparam int REG_IDX_W = 3;
    localparam int NREG      = 1 << REG_IDX_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH,
        ST_DECODE,
        ST_DFETCH,
        ST_ADDR,
        ST_OPFETCH,
        ST_STORE
    } seq_state_e;

    typedef enum logic [1:0] {
        MD_REG   = 2'b00,
        MD_IND   = 2'b01,
        MD_DIR   = 2'b10,
        MD_BDISP = 2'b11
    } addr_mode_e;

    function automatic addr_mode_e opc_mode(input logic [OPC_W-1:0] opc);
        return addr_mode_e'(opc[7:6]);
    endfunction

    function automatic logic [REG_IDX_W-1:0] opc_src(input logic [OPC_W-1:0] opc);
        return opc[5:3];
    endfunction

    function automatic logic [REG_IDX_W-1:0] opc_dst(input logic [OPC_W-1:0] opc);
        return opc[2:0];
    endfunction

endpackage

// File: rtl/mov_seq_regfile.sv
module mov_seq_regfile
    import mov_seq_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we,
    input  logic [REG_IDX_W-1:0] widx,
    input  logic [DW-1:0]        wdata,
    input  logic [REG_IDX_W-1:0] ridx_a,
    output logic [DW-1:0]        rdata_a,
    input  logic [REG_IDX_W-1:0] ridx_b,
    output logic [DW-1:0]        rdata_b
);

    logic [DW-1:0] regs_q [NREG];
    logic [DW-1:0] regs_d [NREG];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_entry
        always_comb begin
            regs_d[gi] = regs_q[gi];
            if (we && widx == REG_IDX_W'(gi)) begin
                regs_d[gi] = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                regs_q[gi] <= '0;
            end else begin
                regs_q[gi] <= regs_d[gi];
            end
        end
    end

    assign rdata_a = regs_q[ridx_a];
    assign rdata_b = regs_q[ridx_b];

endmodule

// File: rtl/mov_seq_agen.sv
module mov_seq_agen
    import mov_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DISPW = 16
) (
    input  addr_mode_e       mode,
    input  logic [AW-1:0]    base_lo,
    input  logic [DISPW-1:0] disp,
    output logic [AW-1:0]    ea
);

    logic [AW-1:0] offset;

    always_comb begin
        offset = '0;
        if (mode == MD_BDISP) begin
            offset = AW'(disp);
        end
        ea = base_lo + offset;
    end

endmodule

// File: rtl/mov_seq_ctrl.sv
module mov_seq_ctrl
    import mov_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DISPW = 16,
    parameter int CW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        start_ip,
    output logic                 mem_re,
    output logic [AW-1:0]        mem_addr,
    input  logic [DW-1:0]        mem_rdata,
    input  logic [DW-1:0]        base_val,
    input  logic [AW-1:0]        ea,
    output addr_mode_e           mode,
    output logic [REG_IDX_W-1:0] src_idx,
    output logic                 core_we,
    output logic [REG_IDX_W-1:0] core_widx,
    output logic [DW-1:0]        core_wdata,
    output logic                 busy,
    output logic                 done,
    output logic [AW-1:0]        ip,
    output logic [CW-1:0]        cycles
);

    localparam logic [AW-1:0] STEP_OPC  = AW'(1);
    localparam logic [AW-1:0] STEP_DISP = AW'(DISPW / 8);
    localparam logic [CW-1:0] CNT_ONE   = CW'(1);

    typedef struct packed {
        seq_state_e       st;
        logic [AW-1:0]    ip;
        logic [OPC_W-1:0] op;
        logic [AW-1:0]    addr;
        logic [CW-1:0]    cnt;
    } ctrl_s;

    ctrl_s r_q, r_d;
    addr_mode_e dec_mode;

    assign dec_mode = opc_mode(mem_rdata[OPC_W-1:0]);

    always_comb begin
        r_d        = r_q;
        mem_re     = 1'b0;
        mem_addr   = r_q.ip;
        core_we    = 1'b0;
        core_wdata = mem_rdata;
        if (r_q.st != ST_IDLE && r_q.st != ST_STORE) begin
            r_d.cnt = r_q.cnt + CNT_ONE;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st  = ST_FETCH;
                    r_d.ip  = start_ip;
                    r_d.cnt = CNT_ONE;
                end
            end
            ST_FETCH: begin
                mem_re   = 1'b1;
                mem_addr = r_q.ip;
                r_d.st   = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.op = mem_rdata[OPC_W-1:0];
                r_d.ip = r_q.ip + STEP_OPC;
                case (dec_mode)
                    MD_REG:  r_d.st = ST_STORE;
                    MD_IND:  r_d.st = ST_ADDR;
                    default: r_d.st = ST_DFETCH;
                endcase
            end
            ST_DFETCH: begin
                mem_re   = 1'b1;
                mem_addr = r_q.ip;
                r_d.st   = (mode == MD_DIR) ? ST_OPFETCH : ST_ADDR;
            end
            ST_ADDR: begin
                r_d.addr = ea;
                if (mode == MD_BDISP) begin
                    r_d.ip = r_q.ip + STEP_DISP;
                end
                r_d.st = ST_OPFETCH;
            end
            ST_OPFETCH: begin
                mem_re = 1'b1;
                if (mode == MD_DIR) begin
                    mem_addr = AW'(mem_rdata[DISPW-1:0]);
                    r_d.ip   = r_q.ip + STEP_DISP;
                end else begin
                    mem_addr = r_q.addr;
                end
                r_d.st = ST_STORE;
            end
            ST_STORE: begin
                core_we = 1'b1;
                if (mode == MD_REG) begin
                    core_wdata = base_val;
                end
                r_d.st = ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, ip: '0, op: '0, addr: '0, cnt: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign mode      = opc_mode(r_q.op);
    assign src_idx   = opc_src(r_q.op);
    assign core_widx = opc_dst(r_q.op);
    assign busy      = (r_q.st != ST_IDLE);
    assign done      = (r_q.st == ST_STORE);
    assign ip        = r_q.ip;
    assign cycles    = r_q.cnt;

    assert_opcode_read_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start) |=> (mem_re && mem_addr == $past(start_ip)));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_no_read_at_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_re);

    assert_read_precedes_store_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode != MD_REG) |-> $past(mem_re));

    assert_reg_mode_three_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode == MD_REG) |-> (cycles == CW'(3)));

    assert_bdisp_mode_six_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (done && mode == MD_BDISP) |-> (cycles == CW'(6)));

    assert_start_ignored_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done && start) |=> busy);

endmodule

// File: rtl/mov_seq.sv
module mov_seq
    import mov_seq_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int DISPW = 16,
    parameter int CW    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start,
    input  logic [AW-1:0]        start_ip,
    output logic                 busy,
    output logic                 done,
    output logic [CW-1:0]        cycles,
    output logic [AW-1:0]        ip,
    output logic                 mem_re,
    output logic [AW-1:0]        mem_addr,
    input  logic [DW-1:0]        mem_rdata,
    input  logic                 ext_we,
    input  logic [REG_IDX_W-1:0] ext_idx,
    input  logic [DW-1:0]        ext_wdata,
    input  logic [REG_IDX_W-1:0] rd_idx,
    output logic [DW-1:0]        rd_data
);

    addr_mode_e           mode;
    logic [REG_IDX_W-1:0] src_idx;
    logic                 core_we;
    logic [REG_IDX_W-1:0] core_widx;
    logic [DW-1:0]        core_wdata;
    logic [DW-1:0]        base_val;
    logic [AW-1:0]        ea;
    logic                 rf_we;
    logic [REG_IDX_W-1:0] rf_widx;
    logic [DW-1:0]        rf_wdata;

    always_comb begin
        rf_we    = core_we || (ext_we && !busy);
        rf_widx  = core_we ? core_widx : ext_idx;
        rf_wdata = core_we ? core_wdata : ext_wdata;
    end

    mov_seq_ctrl #(.AW(AW), .DW(DW), .DISPW(DISPW), .CW(CW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .start_ip   (start_ip),
        .mem_re     (mem_re),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .base_val   (base_val),
        .ea         (ea),
        .mode       (mode),
        .src_idx    (src_idx),
        .core_we    (core_we),
        .core_widx  (core_widx),
        .core_wdata (core_wdata),
        .busy       (busy),
        .done       (done),
        .ip         (ip),
        .cycles     (cycles)
    );

    mov_seq_agen #(.AW(AW), .DISPW(DISPW)) u_agen (
        .mode    (mode),
        .base_lo (base_val[AW-1:0]),
        .disp    (mem_rdata[DISPW-1:0]),
        .ea      (ea)
    );

    mov_seq_regfile #(.DW(DW)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (rf_we),
        .widx    (rf_widx),
        .wdata   (rf_wdata),
        .ridx_a  (src_idx),
        .rdata_a (base_val),
        .ridx_b  (rd_idx),
        .rdata_b (rd_data)
    );

    assert_core_write_only_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_we |-> done);

endmodule

// File: tb/mov_seq_bench.sv
`timescale 1ns/1ps
module mov_seq_bench;

    localparam int AW = 16;
    localparam int DW = 32;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start;
    logic [AW-1:0] start_ip;
    logic          busy, done;
    logic [CW-1:0] cycles;
    logic [AW-1:0] ip;
    logic          mem_re;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rdata;
    logic          ext_we;
    logic [2:0]    ext_idx;
    logic [DW-1:0] ext_wdata;
    logic [2:0]    rd_idx;
    logic [DW-1:0] rd_data;

    int checks = 0;
    int errors = 0;

    logic [7:0]  mem [4096];
    logic [31:0] rm  [8];

    always #2 clk = ~clk;

    mov_seq u_mov_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_ip(start_ip),
        .busy(busy), .done(done), .cycles(cycles), .ip(ip),
        .mem_re(mem_re), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ext_we(ext_we), .ext_idx(ext_idx), .ext_wdata(ext_wdata),
        .rd_idx(rd_idx), .rd_data(rd_data)
    );

    function automatic logic [7:0] mbyte(input int a);
        return mem[a & 12'hFFF];
    endfunction

    function automatic logic [31:0] rd32(input int a);
        return {mbyte(a + 3), mbyte(a + 2), mbyte(a + 1), mbyte(a)};
    endfunction

    always @(posedge clk) begin
        if (mem_re) mem_rdata <= rd32(int'(mem_addr));
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic load_regs(input int seed);
        for (int i = 0; i < 8; i++) begin
            rm[i] = 32'h5A00_0000 + 32'(seed * 97) + 32'(i * 263);
            ext_we = 1'b1; ext_idx = 3'(i); ext_wdata = rm[i];
            tick();
        end
        ext_we = 1'b0;
    endtask

    task automatic run(input logic [7:0] op, input int sip, input bit disturb);
        int md, s, d, disp, ea, ecyc, eip, n;
        logic [31:0] eval;
        mem[sip & 12'hFFF] = op;
        md = int'(op[7:6]); s = int'(op[5:3]); d = int'(op[2:0]);
        disp = int'({mbyte(sip + 2), mbyte(sip + 1)});
        case (md)
            0: ea = 0;
            1: ea = int'(rm[s][15:0]);
            2: ea = disp;
            default: ea = (int'(rm[s][15:0]) + disp) & 16'hFFFF;
        endcase
        eval = (md == 0) ? rm[s] : rd32(ea);
        ecyc = (md == 0) ? 3 : (md == 3) ? 6 : 5;
        eip  = (sip + 1 + ((md >= 2) ? 2 : 0)) & 16'hFFFF;
        start = 1'b1; start_ip = AW'(sip);
        tick();
        chk(mem_re && int'(mem_addr) == sip, "R2 opcode read", longint'(mem_addr), sip);
        start = 1'b0;
        if (disturb) begin
            start = 1'b1; start_ip = AW'(sip ^ 16'h0440);
            ext_we = 1'b1; ext_idx = 3'd5; ext_wdata = 32'hDEAD_BEEF;
        end
        n = 1;
        while (!done && n < 20) begin
            tick();
            start = 1'b0; ext_we = 1'b0;
            n++;
        end
        case (md)
            0: chk(n == ecyc, "R4 reg cycles", n, ecyc);
            1: chk(n == ecyc, "R5 indirect cycles", n, ecyc);
            2: chk(n == ecyc, "R6 direct cycles", n, ecyc);
            default: chk(n == ecyc, "R7 base+disp cycles", n, ecyc);
        endcase
        chk(int'(cycles) == ecyc, "R9 cycle counter", longint'(cycles), ecyc);
        chk(!mem_re, "R12 no read at store", longint'(mem_re), 0);
        tick();
        chk(!done, "R9 done one cycle", longint'(done), 0);
        chk(int'(cycles) == ecyc, "R9 counter held", longint'(cycles), ecyc);
        chk(int'(ip) == eip, disturb ? "R10 ip after ignored start" : "R8 final ip",
            longint'(ip), eip);
        rd_idx = 3'(d);
        #1;
        chk(rd_data == eval, disturb ? "R10 result" : "R3 dst value", longint'(rd_data),
            longint'(eval));
        rm[d] = eval;
        if (disturb) begin
            rd_idx = 3'd5;
            #1;
            chk(rd_data == rm[5], "R11 busy write ignored", longint'(rd_data), longint'(rm[5]));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog R9 actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = 8'((a * 7) ^ (a >> 5) ^ 8'h3C);
        rst_n = 1'b0; start = 1'b0; start_ip = '0;
        ext_we = 1'b0; ext_idx = '0; ext_wdata = '0; rd_idx = '0;
        repeat (3) tick();
        chk(!busy && !done && !mem_re, "R1 reset controls", {busy, done, mem_re}, 0);
        chk(ip == '0 && cycles == '0, "R1 reset ip/cycles", longint'(ip), 0);
        rst_n = 1'b1;
        tick();
        chk(!busy && ip == '0, "R1 after release", longint'(ip), 0);
        load_regs(1);
        rd_idx = 3'd6;
        #1;
        chk(rd_data == rm[6], "R11 idle write accepted", longint'(rd_data), longint'(rm[6]));
        for (int op = 0; op < 256; op++) begin
            load_regs(op);
            run(8'(op), (16'h0100 + op * 13) & 16'h0FFF, 1'b0);
        end
        load_regs(300);
        run(8'hDA, 16'h0A30, 1'b1);
        load_regs(301);
        run(8'hDA, 16'h0FFE, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule